// File: doc/BRIEF.md
# Reference Select and Clock Divider Network

This block models the digital clock-path configuration of a two-stage jitter-cleaning clock generator. Two reference clock inputs are routed to a single selected reference. That reference feeds a phase-comparison divider and two output dividers. The phase-comparison divider uses a 3-bit code that either sets a power-of-two pre-divide ratio or selects one of two bypass routes. Each output divider has its own 2-bit code, which sets a ratio of 4, 8 or 32, or disables the output as though it were in high impedance.

The two PLL stages are not modelled. The selected reference stands in for them, and a 2-bit path-mode output reports which route the current code chooses, so a bench can check the routing and the divided waveforms directly. The reference clocks are treated as slow level signals sampled on the block clock, which must run more than twice as fast as either reference. Both rising and falling reference transitions count as edges.

Top module: `clkpath_cfg`

## Requirements
- R1: When `src_sel` is 0, every divider is fed by `ref_in0`. When it is 1, every divider is fed by `ref_in1`.
- R2: For `ref_div_code` values 0 to 5, `pd_clk` is the selected reference divided by 32·2^code. Each high and each low phase of `pd_clk` lasts 32·2^code reference half-periods.
- R3: For `ref_div_code` 6 (first-stage bypass) and 7 (full bypass), `pd_clk` is held at 0.
- R4: `path_mode` is 2'b00 (normal) for `ref_div_code` 0 to 5, 2'b01 for code 6, and 2'b10 for code 7.
- R5: Output code 2'b01 divides the selected reference by 32, 2'b10 divides it by 8, and 2'b11 divides it by 4, in every path mode. The matching enable flag is high.
- R6: Output code 2'b00 drives the matching enable flag low and holds the matching output clock at 0.
- R7: Outputs A and B follow only their own codes. Changing one code leaves the other output's ratio unchanged.
- R8: In the cycle after any divider's code changes, that divider's output is 0.
- R9: Every divided clock has equal high and low times, so its duty cycle is 50%.
- R10: While `rst_n` is low, `pd_clk`, `outa_clk` and `outb_clk` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the references |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in0 | input | 1 | Reference clock 0 |
| ref_in1 | input | 1 | Reference clock 1 |
| src_sel | input | 1 | Reference select (0 selects ref_in0, 1 selects ref_in1) |
| ref_div_code | input | 3 | Phase-comparison divide or bypass code |
| outa_code | input | 2 | Output A divide or disable code |
| outb_code | input | 2 | Output B divide or disable code |
| pd_clk | output | 1 | Divided reference at the phase-comparison rate |
| path_mode | output | 2 | Route indication: normal, first-stage bypass, full bypass |
| outa_clk | output | 1 | Output A clock |
| outa_oe | output | 1 | Output A enable |
| outb_clk | output | 1 | Output B clock |
| outb_oe | output | 1 | Output B enable |

## Verification
The bench builds the block with its defaults: a fixed feedback exponent of 5 on a pre-divide range of up to 32, and a longest output ratio of 32. Together these give phase-comparison ratios of 32 to 1024 reference periods. The reference half-periods are kept to one to three block cycles, so even the longest ratio gives a phase lasting at most about three thousand cycles. That keeps every ratio, both bypass codes and every output code within a single run, while random stimulus exercises mixes of source, code and reference speed.

// File: rtl/clkpath_pkg.sv
// Shared types and code decoding for the clock-path configuration block.
// Assumes the fixed code values of the reference and output selectors.
package clkpath_pkg;

    typedef enum logic [1:0] {
        PATH_NORMAL   = 2'b00,
        PATH_SKIP_JA  = 2'b01,
        PATH_SKIP_ALL = 2'b10
    } path_mode_e;

    localparam int REF_CODE_W = 3;
    localparam int OUT_CODE_W = 2;

    // Route selected by a reference divider code.
    function automatic path_mode_e path_of(input logic [REF_CODE_W-1:0] code);
        case (code)
            3'b110:  return PATH_SKIP_JA;
            3'b111:  return PATH_SKIP_ALL;
            default: return PATH_NORMAL;
        endcase
    endfunction

    // Log2 of the output ratio; 0 stands for the disabled code.
    function automatic int out_log2(input logic [OUT_CODE_W-1:0] code);
        case (code)
            2'b01:   return 5;
            2'b10:   return 3;
            2'b11:   return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/clkpath_refsel.sv
// Reference selector and edge detector.
// Picks one of two reference levels, registers it, and flags each
// transition (rising or falling) as a one-cycle pulse.
// Assumes each reference is slower than half the block clock.
module clkpath_refsel (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in0,
    input  logic ref_in1,
    input  logic src_sel,
    output logic ref_edge
);

    logic sel_q;
    logic sel_qq;

    // Sample the selected reference and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            sel_qq <= 1'b0;
        end else begin
            sel_q  <= src_sel ? ref_in1 : ref_in0;
            sel_qq <= sel_q;
        end
    end

    assign ref_edge = sel_q ^ sel_qq;

endmodule

// File: rtl/clkpath_div.sv
// Power-of-two edge-counting divider.
// Toggles its output every 2^k reference edges, which gives a ratio of 2^k
// reference periods with a 50% duty cycle. A change of the configuration
// word, or a low enable, clears the count and the output synchronously.
// Assumes k is at least 1 and at most CNT_W.
module clkpath_div #(
    parameter int CNT_W = 10,
    parameter int CFG_W = 3,
    localparam int K_W  = $clog2(CNT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_edge,
    input  logic [CFG_W-1:0] cfg,
    input  logic             en,
    input  logic [K_W-1:0]   k,
    output logic             div_out
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [CFG_W-1:0] cfg_q;
    logic             q;

    // Terminal count: 2^k - 1 edges.
    always_comb lim = CNT_W'((32'd1 << k) - 32'd1);

    // Count edges, toggle at the terminal count, restart on a code change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            q     <= 1'b0;
            cfg_q <= cfg;
        end else begin
            cfg_q <= cfg;
            if ((cfg != cfg_q) || !en) begin
                cnt <= '0;
                q   <= 1'b0;
            end else if (ref_edge) begin
                if (cnt == lim) begin
                    cnt <= '0;
                    q   <= ~q;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign div_out = q;

endmodule

// File: rtl/clkpath_cfg.sv
// Clock-path configuration top.
// Selects a reference, divides it to the phase-comparison rate (or drops
// that path in the bypass modes), reports the route, and feeds two
// independently coded output dividers with disable states.
// Assumes references slower than clk/2; the PLL stages are pass-through.
module clkpath_cfg
    import clkpath_pkg::*;
#(
    parameter int PD_FB_LOG2   = 5,
    parameter int REF_MAX_LOG2 = 5,
    parameter int OUT_MAX_LOG2 = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in0,
    input  logic       ref_in1,
    input  logic       src_sel,
    input  logic [2:0] ref_div_code,
    input  logic [1:0] outa_code,
    input  logic [1:0] outb_code,
    output logic       pd_clk,
    output logic [1:0] path_mode,
    output logic       outa_clk,
    output logic       outa_oe,
    output logic       outb_clk,
    output logic       outb_oe
);

    localparam int PD_CNT_W  = PD_FB_LOG2 + REF_MAX_LOG2;
    localparam int PD_K_W    = $clog2(PD_CNT_W + 1);
    localparam int OUT_CNT_W = OUT_MAX_LOG2;
    localparam int OUT_K_W   = $clog2(OUT_CNT_W + 1);
    localparam int N_OUT     = 2;

    logic                  ref_edge;
    logic [PD_K_W-1:0]     pd_k;
    logic                  pd_en;
    logic [OUT_CODE_W-1:0] out_code [N_OUT];
    logic [N_OUT-1:0]      out_oe;
    logic [N_OUT-1:0]      out_q;

    clkpath_refsel u_refsel (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in0  (ref_in0),
        .ref_in1  (ref_in1),
        .src_sel  (src_sel),
        .ref_edge (ref_edge)
    );

    // Phase-comparison ratio: fixed feedback exponent plus pre-divide code.
    always_comb begin
        pd_en = (path_of(ref_div_code) == PATH_NORMAL);
        pd_k  = PD_K_W'(PD_FB_LOG2 + int'(ref_div_code));
    end

    clkpath_div #(
        .CNT_W (PD_CNT_W),
        .CFG_W (REF_CODE_W)
    ) u_pd_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_edge (ref_edge),
        .cfg      (ref_div_code),
        .en       (pd_en),
        .k        (pd_k),
        .div_out  (pd_clk)
    );

    assign path_mode   = path_of(ref_div_code);
    assign out_code[0] = outa_code;
    assign out_code[1] = outb_code;

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        logic [OUT_K_W-1:0] k_i;

        // Enable and ratio decoded from this output's code alone.
        always_comb begin
            out_oe[i] = (out_code[i] != 2'b00);
            k_i       = OUT_K_W'(out_log2(out_code[i]));
        end

        clkpath_div #(
            .CNT_W (OUT_CNT_W),
            .CFG_W (OUT_CODE_W)
        ) u_out_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .ref_edge (ref_edge),
            .cfg      (out_code[i]),
            .en       (out_oe[i]),
            .k        (k_i),
            .div_out  (out_q[i])
        );
    end

    assign outa_oe  = out_oe[0];
    assign outb_oe  = out_oe[1];
    assign outa_clk = out_oe[0] & out_q[0];
    assign outb_clk = out_oe[1] & out_q[1];

endmodule

// File: rtl/clkpath_cfg_chk.sv
// Port-level property checker for clkpath_cfg, attached by bind.
// Assumes the reset is held from time zero.
module clkpath_cfg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] ref_div_code,
    input logic [1:0] outa_code,
    input logic [1:0] outb_code,
    input logic       pd_clk,
    input logic [1:0] path_mode,
    input logic       outa_clk,
    input logic       outa_oe,
    input logic       outb_clk,
    input logic       outb_oe
);

    AST_HIZ_A_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (outa_code == 2'b00) |-> (!outa_oe && !outa_clk)); // R6
    AST_HIZ_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (outb_code == 2'b00) |-> (!outb_oe && !outb_clk)); // R6
    AST_OUT_A_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (outa_code != 2'b00) |-> outa_oe); // R5
    AST_PATH_SKIP_JA: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_div_code == 3'b110) |-> (path_mode == 2'b01)); // R4
    AST_PATH_SKIP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_div_code == 3'b111) |-> (path_mode == 2'b10)); // R4
    AST_PD_HELD_IN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ref_div_code[2:1] == 2'b11) && ($past(ref_div_code[2:1]) == 2'b11)) |-> !pd_clk); // R3
    AST_RESTART_A: assert property (@(posedge clk) disable iff (!rst_n)
        (outa_code != $past(outa_code)) |=> !outa_clk); // R8
    AST_RESTART_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_div_code != $past(ref_div_code)) |=> !pd_clk); // R8

endmodule

bind clkpath_cfg clkpath_cfg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_div_code (ref_div_code),
    .outa_code    (outa_code),
    .outb_code    (outb_code),
    .pd_clk       (pd_clk),
    .path_mode    (path_mode),
    .outa_clk     (outa_clk),
    .outa_oe      (outa_oe),
    .outb_clk     (outb_clk),
    .outb_oe      (outb_oe)
);

// File: tb/clkpath_cfg_bench.sv
`timescale 1ns/1ps
module clkpath_cfg_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in0 = 1'b0;
    logic       ref_in1 = 1'b0;
    logic       src_sel = 1'b0;
    logic [2:0] ref_div_code = 3'd0;
    logic [1:0] outa_code = 2'd3;
    logic [1:0] outb_code = 2'd2;
    logic       pd_clk;
    logic [1:0] path_mode;
    logic       outa_clk, outa_oe, outb_clk, outb_oe;

    int checks = 0;
    int fails  = 0;
    int h0 = 2;
    int h1 = 3;
    localparam int LIM = 8000;

    always #2.5 clk = ~clk;

    clkpath_cfg u_clkpath_cfg (
        .clk (clk), .rst_n (rst_n), .ref_in0 (ref_in0), .ref_in1 (ref_in1),
        .src_sel (src_sel), .ref_div_code (ref_div_code),
        .outa_code (outa_code), .outb_code (outb_code), .pd_clk (pd_clk),
        .path_mode (path_mode), .outa_clk (outa_clk), .outa_oe (outa_oe),
        .outb_clk (outb_clk), .outb_oe (outb_oe)
    );

    // Reference generators: each toggles every h0 / h1 cycles.
    initial begin
        int c0 = 0;
        int c1 = 0;
        forever begin
            @(negedge clk);
            if (c0 >= h0 - 1) begin ref_in0 = ~ref_in0; c0 = 0; end else c0++;
            if (c1 >= h1 - 1) begin ref_in1 = ~ref_in1; c1 = 0; end else c1++;
        end
    end

    function automatic int exp_out_half(input logic [1:0] code, input int h);
        case (code)
            2'b01:   return 32 * h;
            2'b10:   return 8 * h;
            2'b11:   return 4 * h;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_pd_half(input logic [2:0] code, input int h);
        if (code <= 3'd5) return (1 << code) * 32 * h;
        return 0;
    endfunction

    function automatic logic pick(input int sig);
        case (sig)
            0:       return outa_clk;
            1:       return outb_clk;
            default: return pd_clk;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Skip to the first transition, then time one high and one low phase.
    task automatic meas(input int sig, output int hi, output int lo);
        logic prev, cur;
        int n;
        hi = -1; lo = -1;
        prev = pick(sig);
        n = 0;
        do begin @(negedge clk); cur = pick(sig); n++; end
        while (cur == prev && n < LIM);
        for (int k = 0; k < 2; k++) begin
            prev = cur;
            n = 0;
            do begin @(negedge clk); cur = pick(sig); n++; end
            while (cur == prev && n < LIM);
            if (prev) hi = n; else lo = n;
        end
    endtask

    // Count cycles on which a signal is high over a window.
    task automatic ones_in(input int sig, input int cyc, output int ones);
        ones = 0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (pick(sig)) ones++;
        end
    endtask

    task automatic chk_ratio(input string req, input int sig, input int exp);
        int hi, lo;
        meas(sig, hi, lo);
        chk({req, " high"}, hi, exp);
        chk({"R9 ", req, " low"}, lo, exp);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int ones;
        void'($urandom(32'd20250611));
        // R10: reset state
        repeat (6) @(negedge clk);
        chk("R10 pd", int'(pd_clk), 0);
        chk("R10 outa", int'(outa_clk), 0);
        chk("R10 outb", int'(outb_clk), 0);
        rst_n = 1'b1;
        settle();

        // R1: source select with distinct reference speeds
        chk_ratio("R1 src0 A/4", 0, 4 * 2);
        src_sel = 1'b1; settle();
        chk_ratio("R1 src1 A/4", 0, 4 * 3);
        src_sel = 1'b0; settle();

        // R2 and R4: every pre-divide code on a fast reference
        h0 = 1;
        for (int c = 0; c < 6; c++) begin
            ref_div_code = 3'(c); settle();
            chk("R4 normal", int'(path_mode), 0);
            chk_ratio("R2 pd", 2, exp_pd_half(3'(c), 1));
        end

        // R3 and R4: bypass routes
        ref_div_code = 3'b110; @(negedge clk);
        chk("R4 skip1", int'(path_mode), 1);
        ones_in(2, 300, ones); chk("R3 pd skip1", ones, 0);
        ref_div_code = 3'b111; @(negedge clk);
        chk("R4 skipall", int'(path_mode), 2);
        ones_in(2, 300, ones); chk("R3 pd skipall", ones, 0);
        // R5: output ratio unaffected by full bypass
        outa_code = 2'b10; settle();
        chk_ratio("R5 A/8 bypass", 0, 8);

        // R6: disabled output
        outa_code = 2'b00; @(negedge clk);
        chk("R6 oe", int'(outa_oe), 0);
        ones_in(0, 200, ones); chk("R6 clk", ones, 0);

        // R7: independent outputs
        ref_div_code = 3'd0; h0 = 2;
        outa_code = 2'b01; outb_code = 2'b11; settle();
        chk_ratio("R7 A/32", 0, 64);
        chk_ratio("R7 B/4", 1, 8);
        outa_code = 2'b10; settle();
        chk_ratio("R7 B after A change", 1, 8);

        // R8: restart on code change while output is high
        begin
            int n = 0;
            while (!outa_clk && n < LIM) begin @(negedge clk); n++; end
        end
        outa_code = 2'b11; @(negedge clk);
        chk("R8 restart", int'(outa_clk), 0);

        // Random mixes
        for (int it = 0; it < 12; it++) begin
            logic [2:0] rc;
            logic [1:0] ac, bc;
            int hsel;
            src_sel = 1'($urandom_range(0, 1));
            h0 = $urandom_range(1, 2);
            h1 = $urandom_range(1, 2);
            rc = 3'($urandom_range(0, 7));
            ac = 2'($urandom_range(0, 3));
            bc = 2'($urandom_range(0, 3));
            ref_div_code = rc; outa_code = ac; outb_code = bc;
            hsel = src_sel ? h1 : h0;
            settle();
            chk("R4 rand", int'(path_mode), (rc == 3'd6) ? 1 : (rc == 3'd7) ? 2 : 0);
            if (ac == 2'b00) begin
                ones_in(0, 100, ones); chk("R6 rand A", ones, 0);
            end else chk_ratio("R5 rand A", 0, exp_out_half(ac, hsel));
            if (bc == 2'b00) begin
                chk("R6 rand B oe", int'(outb_oe), 0);
            end else chk_ratio("R5 rand B", 1, exp_out_half(bc, hsel));
            if (rc > 3'd5) begin
                ones_in(2, 100, ones); chk("R3 rand", ones, 0);
            end else chk_ratio("R2 rand", 2, exp_pd_half(rc, hsel));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule